// File: doc/BRIEF.md
# Two-Pass Resonant Pulse Terminal Selector

This block decides which two of six converter terminals take part in the next resonant current pulse. On a start strobe it takes a snapshot of one signed error word and one voltage-sign bit for each terminal. It also captures the direction of the coming resonant half wave. It then runs two serial scans, one terminal per clock. The first scan finds the terminal whose error most needs the charge that the pulse carries. The second scan finds a partner among the other terminals, and only terminals whose voltage sign is opposite to the first pick are eligible.

The selection is deliberately loose. The sign of a terminal's own error never disqualifies it. A pulse can therefore always go ahead as long as a terminal of opposite voltage polarity exists, even if the partner's own error gets worse. When no such partner exists, the block reports that fact instead of a pair. The error integrators and the thyristor firing logic are outside this block.

Top module: `pulse_pair_selector`

## Requirements
- R1: While reset is held and after it is released, `pairValid` and `noCandidate` are 0 and both index outputs are 0.
- R2: A start that is accepted at a clock edge samples all inputs at that edge. Exactly 13 clock edges later (two six-step scans plus one publish cycle), exactly one of `pairValid` or `noCandidate` rises, for one cycle only.
- R3: In the first scan, with `curDirNeg`=0 (positive half wave) the terminal with the smallest signed error is chosen. With `curDirNeg`=1 the terminal with the largest signed error is chosen. `firstIdx` reports it as an index 0..5. Terminal k's error is `errIn[16k+15:16k]`, in two's complement.
- R4: Ties are resolved towards the lower index. A terminal whose error equals the best found so far does not replace it.
- R5: The second scan skips the first pick. It considers only terminals whose sign bit differs from the first pick's sign bit (`vSignNeg[k]`=1 means negative voltage). Among those it chooses by the R3 rule and the R4 tie rule, and reports the choice in `secondIdx`.
- R6: The sign of an error value does not affect eligibility. For example, when every error is positive on a positive half wave, a pair is still produced.
- R7: If no terminal qualifies in the second scan, `noCandidate` pulses instead of `pairValid`. `firstIdx` still reports the first pick and `secondIdx` is 0.
- R8: A start that arrives while a selection is in progress, including the publish cycle, is ignored. Input changes after the accepted start edge do not alter the result.
- R9: `firstIdx` and `secondIdx` hold their values between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new selection |
| curDirNeg | input | 1 | Coming half wave direction, 1 = negative |
| errIn | input | 96 | Six 16-bit signed errors, terminal k at bits 16k+15:16k |
| vSignNeg | input | 6 | Voltage sign per terminal, 1 = negative |
| firstIdx | output | 3 | Index of the first-scan pick |
| secondIdx | output | 3 | Index of the second-scan pick |
| pairValid | output | 1 | One-cycle pulse: both picks valid |
| noCandidate | output | 1 | One-cycle pulse: no opposite-sign partner |

## Verification
Every result is due exactly 13 edges after the edge that accepts a start, and the index outputs must stay frozen at every other time. A behavioural model in the bench applies the same acceptance rule at each rising edge, counts down to the publish edge, and compares all four outputs at every falling edge. A result that is early, late or stretched therefore fails in the cycle where it goes wrong. Directed patterns cover ties, all-positive errors, the case with no partner, and starts that arrive during a scan or while inputs change mid-scan. Random patterns cover both half-wave directions.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } tselState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic evalStep;
    logic passTwo;
    logic closeFirst;
    logic publish;
  } tselCtrl_t;
endpackage

// File: rtl/tsel_ctrl.sv
module tsel_ctrl
  import tsel_pkg::*;
#(
  parameter int NUM_TERM = 6,
  localparam int IDX_W = $clog2(NUM_TERM)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output tselCtrl_t        ctl,
  output logic [IDX_W-1:0] stepIdx
);
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(NUM_TERM - 1);

  tselState_e state;
  logic       passTwo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      passTwo <= 1'b0;
      stepIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_SCAN;
          passTwo <= 1'b0;
          stepIdx <= '0;
        end
        ST_SCAN: begin
          if (stepIdx == LAST_STEP) begin
            stepIdx <= '0;
            if (passTwo) state <= ST_DONE;
            else         passTwo <= 1'b1;
          end else begin
            stepIdx <= stepIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture    = (state == ST_IDLE) && start;
    ctl.evalStep   = (state == ST_SCAN);
    ctl.passTwo    = passTwo;
    ctl.closeFirst = (state == ST_SCAN) && !passTwo && (stepIdx == LAST_STEP);
    ctl.publish    = (state == ST_DONE);
  end

  // R2: the scan index never leaves the terminal range
  a_r2_step_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> (stepIdx <= LAST_STEP));

  // R2: a scan runs uninterrupted until the final step of the second pass
  a_r2_scan_continues: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SCAN) && !(passTwo && stepIdx == LAST_STEP)) |=> (state == ST_SCAN));

  // R8: a start strobe during the scan leaves the step counter advancing
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SCAN) && stepIdx != LAST_STEP) |=> (stepIdx == $past(stepIdx) + 1'b1));
endmodule

// File: rtl/tsel_dpath.sv
module tsel_dpath
  import tsel_pkg::*;
#(
  parameter int NUM_TERM = 6,
  parameter int ERR_W    = 16,
  localparam int IDX_W   = $clog2(NUM_TERM)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tselCtrl_t                 ctl,
  input  logic [IDX_W-1:0]          stepIdx,
  input  logic                      curDirNeg,
  input  logic [NUM_TERM*ERR_W-1:0] errIn,
  input  logic [NUM_TERM-1:0]       vSignNeg,
  output logic [IDX_W-1:0]          firstIdx,
  output logic [IDX_W-1:0]          secondIdx,
  output logic                      pairValid,
  output logic                      noCandidate
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TERM - 1);

  logic signed [ERR_W-1:0] errSnap [NUM_TERM];
  logic [NUM_TERM-1:0]     signSnap;
  logic                    dirSnap;

  logic signed [ERR_W-1:0] bestErr;
  logic [IDX_W-1:0]        bestIdx;
  logic                    bestSign;
  logic                    haveBest;
  logic [IDX_W-1:0]        firstSel;
  logic                    firstSign;

  logic signed [ERR_W-1:0] candErr;
  logic                    candSign;
  logic                    eligible;
  logic                    beats;
  logic                    tempSel;

  // per-terminal snapshot registers
  for (genvar k = 0; k < NUM_TERM; k++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rstN) begin
        errSnap[k]  <= '0;
        signSnap[k] <= 1'b0;
      end else if (ctl.capture) begin
        errSnap[k]  <= errIn[k*ERR_W +: ERR_W];
        signSnap[k] <= vSignNeg[k];
      end
    end
  end

  always_comb begin
    candErr  = '0;
    candSign = 1'b0;
    for (int k = 0; k < NUM_TERM; k++) begin
      if (stepIdx == IDX_W'(k)) begin
        candErr  = errSnap[k];
        candSign = signSnap[k];
      end
    end
    eligible = !ctl.passTwo || ((stepIdx != firstSel) && (candSign != firstSign));
    beats    = !haveBest || (dirSnap ? (candErr > bestErr) : (candErr < bestErr));
    tempSel  = ctl.evalStep && eligible && beats;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirSnap   <= 1'b0;
      bestErr   <= '0;
      bestIdx   <= '0;
      bestSign  <= 1'b0;
      haveBest  <= 1'b0;
      firstSel  <= '0;
      firstSign <= 1'b0;
    end else if (ctl.capture) begin
      dirSnap  <= curDirNeg;
      haveBest <= 1'b0;
    end else if (ctl.evalStep) begin
      if (tempSel) begin
        bestErr  <= candErr;
        bestIdx  <= stepIdx;
        bestSign <= candSign;
        haveBest <= 1'b1;
      end
      if (ctl.closeFirst) begin
        firstSel  <= tempSel ? stepIdx  : bestIdx;
        firstSign <= tempSel ? candSign : bestSign;
        haveBest  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstIdx    <= '0;
      secondIdx   <= '0;
      pairValid   <= 1'b0;
      noCandidate <= 1'b0;
    end else begin
      pairValid   <= ctl.publish && haveBest;
      noCandidate <= ctl.publish && !haveBest;
      if (ctl.publish) begin
        firstIdx  <= firstSel;
        secondIdx <= haveBest ? bestIdx : '0;
      end
    end
  end

  // R2: results are single-cycle pulses
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid);
  a_r2_none_pulse: assert property (@(posedge clk) disable iff (!rstN)
    noCandidate |=> !noCandidate);

  // R7: never both a pair and a no-candidate report
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pairValid && noCandidate));

  // R5: the partner is never the first pick
  a_r5_distinct: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> (firstIdx != secondIdx) && (secondIdx <= LAST_IDX));

  // R7: no partner reports a zero second index
  a_r7_zero_second: assert property (@(posedge clk) disable iff (!rstN)
    noCandidate |-> (secondIdx == '0) && (firstIdx <= LAST_IDX));

  // R9: indices only move on a publish strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.publish |=> ($stable(firstIdx) && $stable(secondIdx)));
endmodule

// File: rtl/pulse_pair_selector.sv
module pulse_pair_selector
  import tsel_pkg::*;
#(
  parameter int NUM_TERM = 6,
  parameter int ERR_W    = 16,
  localparam int IDX_W   = $clog2(NUM_TERM)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      curDirNeg,
  input  logic [NUM_TERM*ERR_W-1:0] errIn,
  input  logic [NUM_TERM-1:0]       vSignNeg,
  output logic [IDX_W-1:0]          firstIdx,
  output logic [IDX_W-1:0]          secondIdx,
  output logic                      pairValid,
  output logic                      noCandidate
);
  tselCtrl_t        ctl;
  logic [IDX_W-1:0] stepIdx;

  tsel_ctrl #(.NUM_TERM(NUM_TERM)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctl     (ctl),
    .stepIdx (stepIdx)
  );

  tsel_dpath #(.NUM_TERM(NUM_TERM), .ERR_W(ERR_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .stepIdx     (stepIdx),
    .curDirNeg   (curDirNeg),
    .errIn       (errIn),
    .vSignNeg    (vSignNeg),
    .firstIdx    (firstIdx),
    .secondIdx   (secondIdx),
    .pairValid   (pairValid),
    .noCandidate (noCandidate)
  );
endmodule

// File: tb/pulse_pair_selector_tb.sv
module pulse_pair_selector_tb;
  localparam int NT = 6;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          curDirNeg = 1'b0;
  logic [NT*EW-1:0] errIn = '0;
  logic [NT-1:0] vSignNeg = '0;
  logic [2:0]    firstIdx, secondIdx;
  logic          pairValid, noCandidate;

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string curTag = "R1";

  // reference model state
  int cnt = 0;
  int expFirst = 0, expSecond = 0, pendFirst = 0, pendSecond = 0;
  bit expValid = 0, expNone = 0, pendFound = 0;

  always #2 clk = ~clk;

  pulse_pair_selector u_dut (
    .clk(clk), .rstN(rstN), .start(start), .curDirNeg(curDirNeg),
    .errIn(errIn), .vSignNeg(vSignNeg), .firstIdx(firstIdx),
    .secondIdx(secondIdx), .pairValid(pairValid), .noCandidate(noCandidate)
  );

  function automatic int errOf(int k);
    return int'($signed(errIn[k*EW +: EW]));
  endfunction

  function automatic bit better(int a, int b, bit neg);
    return neg ? (a > b) : (a < b);
  endfunction

  // behavioural model, evaluated at every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      cnt = 0; expFirst = 0; expSecond = 0; expValid = 0; expNone = 0;
    end else begin
      expValid = 0; expNone = 0;
      if (cnt > 0) begin
        if (cnt == 1) begin
          expFirst = pendFirst;
          if (pendFound) begin expValid = 1; expSecond = pendSecond; end
          else begin expNone = 1; expSecond = 0; end
        end
        cnt--;
      end else if (start) begin
        int best;
        best = errOf(0); pendFirst = 0;
        for (int k = 1; k < NT; k++)
          if (better(errOf(k), best, curDirNeg)) begin best = errOf(k); pendFirst = k; end
        pendFound = 0; pendSecond = 0;
        for (int k = 0; k < NT; k++) begin
          if (k != pendFirst && vSignNeg[k] != vSignNeg[pendFirst]) begin
            if (!pendFound || better(errOf(k), best, curDirNeg)) begin
              best = errOf(k); pendSecond = k; pendFound = 1;
            end
          end
        end
        cnt = 13;
      end
    end
  end

  // compare every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (firstIdx !== 3'(expFirst) || secondIdx !== 3'(expSecond) ||
          pairValid !== expValid || noCandidate !== expNone) begin
        fails++;
        $display("FAIL %s: got first=%0d second=%0d valid=%0b none=%0b, expected first=%0d second=%0d valid=%0b none=%0b",
                 curTag, firstIdx, secondIdx, pairValid, noCandidate,
                 expFirst, expSecond, expValid, expNone);
      end
    end
  end

  task automatic setErrs(int e0, int e1, int e2, int e3, int e4, int e5);
    errIn[0*EW +: EW] = EW'(e0); errIn[1*EW +: EW] = EW'(e1);
    errIn[2*EW +: EW] = EW'(e2); errIn[3*EW +: EW] = EW'(e3);
    errIn[4*EW +: EW] = EW'(e4); errIn[5*EW +: EW] = EW'(e5);
  endtask

  task automatic runOne(string tag);
    curTag = tag;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (15) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got no end, expected end before timeout");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    curTag = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3: positive half wave takes the most negative error (index 3)
    curDirNeg = 0; vSignNeg = 6'b101010;
    setErrs(100, -50, 20, -300, 7, -299);
    runOne("R3");
    // R3: negative half wave takes the most positive error
    curDirNeg = 1; runOne("R3");
    // R4: all equal errors keep the lowest index in both passes
    curDirNeg = 0; vSignNeg = 6'b111000; setErrs(-5, -5, -5, -5, -5, -5);
    runOne("R4");
    curDirNeg = 1; vSignNeg = 6'b000111; runOne("R4");
    // R5: partner restricted to opposite voltage sign, worst error among them
    curDirNeg = 0; vSignNeg = 6'b100001; setErrs(-1000, -900, 5, -800, 3, -2000);
    runOne("R5");
    // R6: all errors positive still give a pair
    curDirNeg = 0; vSignNeg = 6'b010101; setErrs(400, 300, 200, 100, 600, 500);
    runOne("R6");
    // R7: same voltage sign everywhere, no partner
    vSignNeg = 6'b111111; runOne("R7");
    vSignNeg = 6'b000000; curDirNeg = 1; runOne("R7");
    // R8: start and input changes during a scan are ignored
    curTag = "R8"; curDirNeg = 0; vSignNeg = 6'b001100; setErrs(1, 2, 3, 4, 5, 6);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    setErrs(-9, -9, -9, -9, -9, -9); vSignNeg = 6'b111110; curDirNeg = 1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    // R8: start held high, back-to-back accepts only when idle
    start = 1'b1; setErrs(-32768, 32767, 0, -1, 1, -32768); vSignNeg = 6'b011010;
    repeat (45) @(negedge clk);
    start = 1'b0;
    // R9: outputs hold through idle cycles
    curTag = "R9"; repeat (20) @(negedge clk);
    // R2: random patterns, both directions
    for (int n = 0; n < 60; n++) begin
      for (int k = 0; k < NT; k++) errIn[k*EW +: EW] = EW'($urandom);
      if (n % 5 == 0) for (int k = 0; k < NT; k++) errIn[k*EW +: EW] = EW'($urandom_range(0, 3));
      vSignNeg = 6'($urandom); curDirNeg = 1'($urandom);
      runOne("R2");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule